// File: doc/BRIEF.md
# Per-Pin Access Filter with Hardware Semaphores

This block sits beside a 16-pin I/O port's register bank and decides, pin by pin, which bus requesters may change that pin's configuration. Each request carries a compartment number, a secure flag and a privileged flag. The filter keeps three bank-wide masks with one bit per pin: secure-only pins, privileged-only pins and locked pins. It also keeps a compartment configuration word and a hardware semaphore for each pin.

A pin can be owned in one of two ways. It can be assigned statically to one compartment. It can also be claimed at run time through its semaphore, which only compartments named in that pin's whitelist may take. The block drives a combinational grant vector for the requester currently on the bus, and the port register bank uses that vector to gate its own writes.

Accesses to a pin's filter registers that break the pin's security rules are refused. A refused access has no effect, and a refused read returns zero. Each refused access raises a one-cycle illegal-access pulse that carries the pin number. Lock bits can only be set, and they stay set until reset.

Top module: `pin_access_filter`

## Requirements
- R1: After reset every mask register, compartment word and semaphore reads as zero, and `pin_grant` is all ones for every requester.
- R2: The secure mask (byte address 0x30) and privilege mask (0x34), one bit per pin in bits 15:0, change only on writes from a requester that is both secure and privileged. Writes from any other requester are ignored.
- R3: The lock mask (0x38) is set-only. Writing 1 to a bit sets it, and no write clears it before reset. A locked pin's bits in the secure and privilege masks, and its compartment word, ignore all writes.
- R4: Pin n's compartment word is at 0x50+8n, with filter enable in bit 0, semaphore mode in bit 1, static compartment in bits 6:4 and whitelist in bits 23:16 (bit 16+c names compartment c). With filtering on and semaphore mode off, only the static compartment is granted the pin.
- R5: Pin n's semaphore word is at 0x54+8n. Writing 1 to bit 0 takes the semaphore only if the pin has filtering and semaphore mode on, the semaphore is free, the requester's whitelist bit is set, and its compartment number is at most SEM_CID_MAX. A read then returns bit 0 set and the owner in bits 6:4. A free semaphore reads zero.
- R6: Writing 0 to bit 0 releases the semaphore only when the writer is the current owner. Writes from other compartments leave it held.
- R7: In semaphore mode only the current owner is granted the pin. While the semaphore is free, no requester is granted it.
- R8: A non-secure requester touching a secure pin's compartment or semaphore word is refused, and so is a non-privileged requester touching a privileged pin's word. A write to a compartment word from a requester that is not both secure and privileged is also refused. A refused write is dropped, a refused read returns zero, and `illegal_pulse` is high for one cycle with `illegal_pin` set to the pin number.
- R9: Read data and `rd_valid` appear one cycle after the request. Unmapped addresses read zero and raise no pulse.
- R10: `pin_grant` is never set for a secure pin when the requester is non-secure, nor for a privileged pin when the requester is unprivileged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| req_cid | input | 3 | Requester compartment number |
| req_secure | input | 1 | Requester is secure |
| req_priv | input | 1 | Requester is privileged |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| illegal_pulse | output | 1 | One-cycle refused-access flag |
| illegal_pin | output | PIDX_W | Pin number of the refused access |
| pin_grant | output | NPINS | Per-pin grant for the current requester |

## Verification
The assertions assume that the requester attributes (`req_cid`, `req_secure`, `req_priv`) hold steady for the whole cycle in which `req_valid` is high, and that the request lasts exactly one cycle. They also assume that only semaphore writes change semaphore ownership. The bench drives every request on the falling edge, holds it for exactly one clock, and returns `req_valid` to zero between requests. The grant vector is sampled with `req_valid` low, so no register access disturbs what is being checked.

// File: rtl/pinflt_pkg.sv
package pinflt_pkg;
   localparam int CID_W = 3;
   localparam int WL_W  = 1 << CID_W;

   localparam logic [7:0] OFS_SECMASK  = 8'h30;
   localparam logic [7:0] OFS_PRIVMASK = 8'h34;
   localparam logic [7:0] OFS_LOCKMASK = 8'h38;
   localparam logic [7:0] OFS_PINBASE  = 8'h50;
   localparam int         PIN_STRIDE   = 8;

   typedef enum logic [2:0] {
      ACC_NONE, ACC_SEC, ACC_PRIV, ACC_LOCK, ACC_CFG, ACC_SEM
   } acc_kind_e;

   typedef struct packed {
      logic [WL_W-1:0]  wl;
      logic [CID_W-1:0] scid;
      logic             semen;
      logic             cfen;
   } pin_cfg_t;
endpackage

// File: rtl/pinflt_decode.sv
module pinflt_decode
   import pinflt_pkg::*;
#(
   parameter int NPINS  = 16,
   parameter int PIDX_W = 4
) (
   input  logic [7:0]        addr,
   output acc_kind_e         kind,
   output logic [PIDX_W-1:0] pin
);
   localparam logic [8:0] PIN_END = 9'(int'(OFS_PINBASE) + PIN_STRIDE * NPINS);

   logic [7:0] off;
   logic       in_pins;
   logic       unused_off;

   assign off        = addr - OFS_PINBASE;
   assign in_pins    = ({1'b0, addr} >= {1'b0, OFS_PINBASE}) && ({1'b0, addr} < PIN_END)
                       && (addr[1:0] == 2'b00);
   assign unused_off = ^{off[7:3], off[1:0]};

   always_comb begin
      kind = ACC_NONE;
      pin  = '0;
      if (addr == OFS_SECMASK)       kind = ACC_SEC;
      else if (addr == OFS_PRIVMASK) kind = ACC_PRIV;
      else if (addr == OFS_LOCKMASK) kind = ACC_LOCK;
      else if (in_pins) begin
         kind = off[2] ? ACC_SEM : ACC_CFG;
         pin  = off[3 +: PIDX_W];
      end
   end
endmodule

// File: rtl/pinflt_attr_regs.sv
module pinflt_attr_regs #(
   parameter int NPINS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sec,
   input  logic             wr_priv,
   input  logic             wr_lock,
   input  logic [NPINS-1:0] wdata,
   output logic [NPINS-1:0] sec_q,
   output logic [NPINS-1:0] priv_q,
   output logic [NPINS-1:0] lock_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q  <= '0;
         priv_q <= '0;
         lock_q <= '0;
      end else begin
         if (wr_sec)  sec_q  <= (sec_q & lock_q) | (wdata & ~lock_q);
         if (wr_priv) priv_q <= (priv_q & lock_q) | (wdata & ~lock_q);
         if (wr_lock) lock_q <= lock_q | wdata;
      end
   end
endmodule

// File: rtl/pinflt_pin_slot.sv
module pinflt_pin_slot
   import pinflt_pkg::*;
#(
   parameter int SEM_CID_MAX = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_cfg,
   input  logic             acc_sem,
   input  logic             wr,
   input  pin_cfg_t         wcfg,
   input  logic             wsem,
   input  logic [CID_W-1:0] cid,
   input  logic             req_sec,
   input  logic             req_priv,
   input  logic             pin_sec,
   input  logic             pin_priv,
   input  logic             pin_lock,
   output logic             grant,
   output logic             refused,
   output logic             sem_taken,
   output logic [CID_W-1:0] sem_owner,
   output logic [31:0]      rdata
);
   localparam logic [CID_W-1:0] SEM_LIM = CID_W'(SEM_CID_MAX);

   pin_cfg_t cfg_q;
   logic     attr_ok, trusted, wl_ok, own_ok, sem_wr_ok;

   assign trusted   = req_sec & req_priv;
   assign attr_ok   = (~pin_sec | req_sec) & (~pin_priv | req_priv);
   assign wl_ok     = (cid <= SEM_LIM) & cfg_q.wl[cid];
   assign own_ok    = sem_taken & (sem_owner == cid);
   assign sem_wr_ok = acc_sem & wr & attr_ok & cfg_q.cfen & cfg_q.semen;

   assign refused = (acc_sem & ~attr_ok) | (acc_cfg & (~attr_ok | (wr & ~trusted)));

   always_comb begin
      if (!cfg_q.cfen)      grant = attr_ok;
      else if (cfg_q.semen) grant = attr_ok & own_ok;
      else                  grant = attr_ok & (cfg_q.scid == cid);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         sem_taken <= 1'b0;
         sem_owner <= '0;
      end else begin
         if (acc_cfg & wr & trusted & ~pin_lock) cfg_q <= wcfg;
         if (sem_wr_ok) begin
            if (wsem & ~sem_taken & wl_ok) begin
               sem_taken <= 1'b1;
               sem_owner <= cid;
            end else if (~wsem & own_ok) begin
               sem_taken <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (!refused) begin
         if (acc_cfg)
            rdata = {8'h00, cfg_q.wl, 9'h000, cfg_q.scid, 2'b00, cfg_q.semen, cfg_q.cfen};
         else if (acc_sem && sem_taken)
            rdata = {25'h0, sem_owner, 3'b000, 1'b1};
      end
   end
endmodule

// File: rtl/pin_access_filter.sv
module pin_access_filter
   import pinflt_pkg::*;
#(
   parameter int NPINS       = 16,
   parameter int SEM_CID_MAX = 3,
   localparam int PIDX_W     = (NPINS > 1) ? $clog2(NPINS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [7:0]        req_addr,
   input  logic [31:0]       req_wdata,
   input  logic [2:0]        req_cid,
   input  logic              req_secure,
   input  logic              req_priv,
   output logic              rd_valid,
   output logic [31:0]       rd_data,
   output logic              illegal_pulse,
   output logic [PIDX_W-1:0] illegal_pin,
   output logic [NPINS-1:0]  pin_grant
);
   if (NPINS < 1 || NPINS > 16) begin : g_bad_npins
      $error("pin_access_filter: NPINS must lie in 1..16");
   end
   if (SEM_CID_MAX < 0 || SEM_CID_MAX >= (1 << CID_W)) begin : g_bad_semmax
      $error("pin_access_filter: SEM_CID_MAX out of compartment range");
   end

   acc_kind_e         kind;
   logic [PIDX_W-1:0] dec_pin;
   logic              trusted, rd_req, refused_any;
   logic [NPINS-1:0]  sec_q, priv_q, lock_q;
   logic [NPINS-1:0]  refused_vec, sem_taken;
   logic [CID_W-1:0]  sem_owner [NPINS];
   logic [NPINS*CID_W-1:0] sem_owner_flat;
   logic [31:0]       slot_rdata [NPINS];
   logic [31:0]       rmux;
   pin_cfg_t          wcfg;
   logic              unused_wbits;

   assign trusted      = req_secure & req_priv;
   assign rd_req       = req_valid & ~req_write;
   assign wcfg         = '{wl: req_wdata[23:16], scid: req_wdata[6:4],
                           semen: req_wdata[1], cfen: req_wdata[0]};
   assign unused_wbits = ^{req_wdata[31:24], req_wdata[15:7], req_wdata[3:2]};

   pinflt_decode #(.NPINS(NPINS), .PIDX_W(PIDX_W)) u_dec (
      .addr (req_addr),
      .kind (kind),
      .pin  (dec_pin)
   );

   pinflt_attr_regs #(.NPINS(NPINS)) u_attr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sec  (req_valid & req_write & trusted & (kind == ACC_SEC)),
      .wr_priv (req_valid & req_write & trusted & (kind == ACC_PRIV)),
      .wr_lock (req_valid & req_write & trusted & (kind == ACC_LOCK)),
      .wdata   (req_wdata[NPINS-1:0]),
      .sec_q   (sec_q),
      .priv_q  (priv_q),
      .lock_q  (lock_q)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_slot
      logic hit;
      assign hit = req_valid & (dec_pin == PIDX_W'(i));
      pinflt_pin_slot #(.SEM_CID_MAX(SEM_CID_MAX)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .acc_cfg   (hit & (kind == ACC_CFG)),
         .acc_sem   (hit & (kind == ACC_SEM)),
         .wr        (req_write),
         .wcfg      (wcfg),
         .wsem      (req_wdata[0]),
         .cid       (req_cid),
         .req_sec   (req_secure),
         .req_priv  (req_priv),
         .pin_sec   (sec_q[i]),
         .pin_priv  (priv_q[i]),
         .pin_lock  (lock_q[i]),
         .grant     (pin_grant[i]),
         .refused   (refused_vec[i]),
         .sem_taken (sem_taken[i]),
         .sem_owner (sem_owner[i]),
         .rdata     (slot_rdata[i])
      );
      assign sem_owner_flat[i*CID_W +: CID_W] = sem_owner[i];
   end

   assign refused_any = |refused_vec;

   always_comb begin
      rmux = '0;
      unique case (kind)
         ACC_SEC:  rmux = 32'(sec_q);
         ACC_PRIV: rmux = 32'(priv_q);
         ACC_LOCK: rmux = 32'(lock_q);
         default: begin
            for (int k = 0; k < NPINS; k++) rmux = rmux | slot_rdata[k];
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid      <= 1'b0;
         rd_data       <= '0;
         illegal_pulse <= 1'b0;
         illegal_pin   <= '0;
      end else begin
         rd_valid      <= rd_req;
         rd_data       <= rd_req ? rmux : '0;
         illegal_pulse <= req_valid & refused_any;
         illegal_pin   <= dec_pin;
      end
   end
endmodule

// File: rtl/pinflt_checker.sv
module pinflt_checker #(
   parameter int NPINS       = 16,
   parameter int SEM_CID_MAX = 3,
   parameter int CID_W       = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic                   req_write,
   input logic                   req_secure,
   input logic [CID_W-1:0]       req_cid,
   input logic                   rd_valid,
   input logic [31:0]            rd_data,
   input logic                   illegal_pulse,
   input logic [NPINS-1:0]       pin_grant,
   input logic [NPINS-1:0]       sec_q,
   input logic [NPINS-1:0]       lock_q,
   input logic [NPINS-1:0]       sem_taken,
   input logic [NPINS*CID_W-1:0] sem_owner_flat
);
   localparam logic [CID_W-1:0] SEM_LIM = CID_W'(SEM_CID_MAX);

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q != '0) |=> ((lock_q & $past(lock_q)) == $past(lock_q))); // R3

   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid); // R9

   AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rd_valid); // R9

   AST_PULSE_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_pulse |-> $past(req_valid)); // R8

   AST_REFUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal_pulse && rd_valid) |-> (rd_data == 32'h0)); // R8

   AST_NONSEC_NO_SECURE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      !req_secure |-> ((pin_grant & sec_q) == '0)); // R10

   for (genvar i = 0; i < NPINS; i++) begin : g_sem
      AST_SEM_RELEASE_BY_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(sem_taken[i]) |-> ($past(req_valid && req_write) &&
            ($past(req_cid) == $past(sem_owner_flat[i*CID_W +: CID_W])))); // R6

      AST_SEM_TAKE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sem_taken[i]) |-> ($past(req_cid) <= SEM_LIM)); // R5
   end
endmodule

bind pin_access_filter pinflt_checker #(.NPINS(NPINS), .SEM_CID_MAX(SEM_CID_MAX)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_write      (req_write),
   .req_secure     (req_secure),
   .req_cid        (req_cid),
   .rd_valid       (rd_valid),
   .rd_data        (rd_data),
   .illegal_pulse  (illegal_pulse),
   .pin_grant      (pin_grant),
   .sec_q          (sec_q),
   .lock_q         (lock_q),
   .sem_taken      (sem_taken),
   .sem_owner_flat (sem_owner_flat)
);

// File: tb/sim_pin_access_filter.sv
`timescale 1ns/1ps
module sim_pin_access_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [2:0]  req_cid = '0;
   logic        req_secure = 1'b0, req_priv = 1'b0;
   logic        rd_valid, illegal_pulse;
   logic [31:0] rd_data;
   logic [3:0]  illegal_pin;
   logic [15:0] pin_grant;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pin_access_filter u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_cid(req_cid),
      .req_secure(req_secure), .req_priv(req_priv), .rd_valid(rd_valid),
      .rd_data(rd_data), .illegal_pulse(illegal_pulse), .illegal_pin(illegal_pin),
      .pin_grant(pin_grant)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one-cycle access; outputs sampled on the following falling edge
   task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                         input logic [2:0] c, input logic s, input logic p,
                         output logic [31:0] rd, output logic ill, output logic [3:0] ipin,
                         output logic rv);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      req_cid = c; req_secure = s; req_priv = p;
      @(negedge clk);
      rd = rd_data; ill = illegal_pulse; ipin = illegal_pin; rv = rd_valid;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic wr_t(input logic [7:0] a, input logic [31:0] d, input logic [2:0] c);
      logic [31:0] r; logic i, v; logic [3:0] ip;
      access(1'b1, a, d, c, 1'b1, 1'b1, r, i, ip, v);
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] r; logic i, v; logic [3:0] ip;
      access(1'b0, a, 32'h0, 3'd0, 1'b1, 1'b1, r, i, ip, v);
      check(tag, r, exp);
   endtask

   task automatic grant_chk(input string tag, input logic [2:0] c, input logic s,
                            input logic p, input logic [15:0] exp);
      @(negedge clk);
      req_valid = 1'b0; req_cid = c; req_secure = s; req_priv = p;
      #1;
      check(tag, 32'(pin_grant), 32'(exp));
   endtask

   task automatic t_reset();
      grant_chk("R1 grant after reset", 3'd5, 1'b0, 1'b0, 16'hFFFF);
      rd_chk("R1 secure mask reset", 8'h30, 32'h0);
      rd_chk("R1 lock mask reset", 8'h38, 32'h0);
      rd_chk("R1 pin3 compartment reset", 8'h68, 32'h0);
      rd_chk("R1 pin3 semaphore reset", 8'h6C, 32'h0);
   endtask

   task automatic t_masks();
      logic [31:0] r; logic i, v; logic [3:0] ip;
      wr_t(8'h30, 32'h0000_00F0, 3'd0);
      rd_chk("R2 secure mask trusted write", 8'h30, 32'h0000_00F0);
      access(1'b1, 8'h30, 32'h0000_FFFF, 3'd0, 1'b1, 1'b0, r, i, ip, v);
      rd_chk("R2 secure mask unprivileged write ignored", 8'h30, 32'h0000_00F0);
      wr_t(8'h34, 32'h0000_0F00, 3'd0);
      access(1'b1, 8'h34, 32'h0, 3'd0, 1'b0, 1'b1, r, i, ip, v);
      rd_chk("R2 privilege mask nonsecure write ignored", 8'h34, 32'h0000_0F00);
   endtask

   task automatic t_attr_grant();
      grant_chk("R10 nonsecure privileged grant", 3'd0, 1'b0, 1'b1, 16'hFF0F);
      grant_chk("R10 nonsecure unprivileged grant", 3'd0, 1'b0, 1'b0, 16'hF00F);
      grant_chk("R10 trusted grant", 3'd0, 1'b1, 1'b1, 16'hFFFF);
   endtask

   task automatic t_refused();
      logic [31:0] r; logic i, v; logic [3:0] ip;
      wr_t(8'h78, 32'h0000_0021, 3'd0);
      access(1'b0, 8'h78, 32'h0, 3'd0, 1'b1, 1'b1, r, i, ip, v);
      check("R8 trusted read of secure pin5", r, 32'h21);
      check("R8 no pulse on trusted read", 32'(i), 32'd0);
      access(1'b0, 8'h78, 32'h0, 3'd2, 1'b0, 1'b1, r, i, ip, v);
      check("R8 refused read returns zero", r, 32'h0);
      check("R8 refused read pulse", 32'(i), 32'd1);
      check("R8 refused read pin index", 32'(ip), 32'd5);
      @(negedge clk);
      check("R8 pulse lasts one cycle", 32'(illegal_pulse), 32'd0);
      access(1'b1, 8'h50, 32'h1, 3'd0, 1'b0, 1'b1, r, i, ip, v);
      check("R8 nonsecure cfg write pulse", 32'(i), 32'd1);
      check("R8 nonsecure cfg write pin", 32'(ip), 32'd0);
      access(1'b1, 8'h50, 32'h1, 3'd0, 1'b1, 1'b0, r, i, ip, v);
      check("R8 unprivileged cfg write pulse", 32'(i), 32'd1);
      rd_chk("R8 refused cfg writes dropped", 8'h50, 32'h0);
      access(1'b1, 8'h74, 32'h1, 3'd0, 1'b0, 1'b1, r, i, ip, v);
      check("R8 nonsecure semaphore write on secure pin4", 32'(ip), 32'd4);
      check("R8 semaphore refusal pulse", 32'(i), 32'd1);
   endtask

   task automatic t_static();
      wr_t(8'h58, 32'h0000_0031, 3'd0);
      grant_chk("R4 static cid3 grant", 3'd3, 1'b1, 1'b1, 16'hFFDF);
      grant_chk("R4 static cid2 grant", 3'd2, 1'b1, 1'b1, 16'hFFFD);
   endtask

   task automatic t_sem();
      wr_t(8'h60, 32'h0006_0003, 3'd0);
      wr_t(8'h64, 32'h1, 3'd3);
      rd_chk("R5 non-whitelisted take fails", 8'h64, 32'h0);
      grant_chk("R7 free semaphore grants nobody", 3'd1, 1'b1, 1'b1, 16'hFFD9);
      wr_t(8'h64, 32'h1, 3'd1);
      rd_chk("R5 whitelisted take records owner", 8'h64, 32'h11);
      grant_chk("R7 owner cid1 granted", 3'd1, 1'b1, 1'b1, 16'hFFDD);
      grant_chk("R7 non-owner cid2 refused", 3'd2, 1'b1, 1'b1, 16'hFFF9);
      wr_t(8'h64, 32'h1, 3'd2);
      rd_chk("R5 take of held semaphore fails", 8'h64, 32'h11);
      wr_t(8'h64, 32'h0, 3'd2);
      rd_chk("R6 release by non-owner ignored", 8'h64, 32'h11);
      wr_t(8'h64, 32'h0, 3'd1);
      rd_chk("R6 release by owner", 8'h64, 32'h0);
      wr_t(8'h64, 32'h1, 3'd2);
      rd_chk("R5 new owner cid2", 8'h64, 32'h21);
      wr_t(8'h68, 32'h0010_0003, 3'd0);
      wr_t(8'h6C, 32'h1, 3'd4);
      rd_chk("R5 compartment above SEM_CID_MAX cannot take", 8'h6C, 32'h0);
      wr_t(8'h5C, 32'h1, 3'd3);
      rd_chk("R5 no take without semaphore mode", 8'h5C, 32'h0);
   endtask

   task automatic t_lock();
      wr_t(8'h38, 32'h0000_0002, 3'd0);
      rd_chk("R3 lock bit set", 8'h38, 32'h2);
      wr_t(8'h38, 32'h0, 3'd0);
      rd_chk("R3 lock cannot be cleared", 8'h38, 32'h2);
      wr_t(8'h58, 32'h0, 3'd0);
      rd_chk("R3 locked compartment word kept", 8'h58, 32'h31);
      wr_t(8'h30, 32'h0000_00F2, 3'd0);
      rd_chk("R3 locked secure bit kept", 8'h30, 32'h0000_00F0);
   endtask

   task automatic t_unmapped();
      logic [31:0] r; logic i, v; logic [3:0] ip;
      access(1'b0, 8'h40, 32'h0, 3'd0, 1'b1, 1'b1, r, i, ip, v);
      check("R9 unmapped read zero", r, 32'h0);
      check("R9 read valid after one cycle", 32'(v), 32'd1);
      check("R9 unmapped no pulse", 32'(i), 32'd0);
      @(negedge clk);
      check("R9 read valid drops", 32'(rd_valid), 32'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_masks();
      t_attr_grant();
      t_refused();
      t_static();
      t_sem();
      t_lock();
      t_unmapped();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule